// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the array address for four-beat bursts of a pipelined synchronous memory. On each clock edge where the part is selected and not stalled, a low level on the advance control captures a fresh external address and starts a new burst. A high level on that control steps the two lowest address bits to the next beat while the upper bits stay fixed, and the external address bus is not looked at.

The beat order is chosen by a mode input that is meant to stay fixed while the block runs. In the linear order the offset counts up modulo four from the starting offset. In the interleaved order the offset is the starting offset XORed with a beat count that runs 0, 1, 2, 3. A stall input freezes all state. A deselect marks the address as not valid, and an advance that arrives with no burst open is dropped.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_o` is zero and `addr_valid_o` and `burst_cont_o` are low.
- R2: On an edge with `stall_i` low, `sel_i` high and `advance_i` low, the next `addr_o` equals `ext_addr_i`, `addr_valid_o` goes high and `burst_cont_o` goes low. This happens even while a burst is running, and it ends that burst.
- R3: On an advance edge (`stall_i` low, `sel_i` high, `advance_i` high) with a burst open, only bits [1:0] of `addr_o` change. The upper bits keep their loaded value, and `ext_addr_i` has no effect.
- R4: With `order_mode_i` = 0 (linear), beat k of a burst started at offset s has offset (s + k) mod 4. Example: a start of 1 gives 1, 2, 3, 0.
- R5: With `order_mode_i` = 1 (interleaved), beat k of a burst started at offset s has offset s XOR k. Example: a start of 1 gives 1, 0, 3, 2.
- R6: One load yields four distinct beats. A fourth advance wraps the offset back to the starting offset and leaves the upper bits untouched.
- R7: While `stall_i` is high, `addr_o`, `addr_valid_o`, `burst_cont_o` and the beat position all hold, whatever the other inputs are.
- R8: On an edge with `stall_i` low and `sel_i` low, `addr_valid_o` and `burst_cont_o` go low on the next cycle.
- R9: An advance edge that arrives when `addr_valid_o` is low leaves `addr_valid_o` low and does not open a burst.
- R10: `burst_cont_o` is high exactly on the valid addresses produced by advance edges, and it is never high while `addr_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | High: hold every register |
| sel_i | input | 1 | Chip selected, active high |
| advance_i | input | 1 | Low: load an external address; high: step the burst |
| order_mode_i | input | 1 | Static beat order: 0 linear, 1 interleaved |
| ext_addr_i | input | ADDR_W | External address, sampled on load edges |
| addr_o | output | ADDR_W | Current array address |
| addr_valid_o | output | 1 | `addr_o` holds a live address |
| burst_cont_o | output | 1 | `addr_o` comes from a burst advance, not a load |

## Verification
The sequence check loads every one of the four starting offsets in both orders, then advances three times and once more. The four starting offsets tell the modulo-four add apart from the XOR, and the extra advance shows that the wrap returns to the start and leaves the upper bits alone. During every advance the external bus carries all-ones junk, so any leak of `ext_addr_i` into the address shows up. A stall placed in the middle of a burst, with deselect and advance driven at the same time, separates freezing from stepping. A deselect followed by an advance, and a reload in the middle of a burst, show that an advance with no burst open is dropped and that a load restarts the beat count.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Decoded per-edge command, priority stall > deselect > load > advance
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_DESEL = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_ADV   = 2'd3
    } burst_cmd_e;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_addr_pkg::*;
(
    input  logic       stall_i,
    input  logic       sel_i,
    input  logic       advance_i,
    output burst_cmd_e cmd_o
);

    always_comb begin
        if (stall_i) begin
            cmd_o = CMD_HOLD;
        end else if (!sel_i) begin
            cmd_o = CMD_DESEL;
        end else if (!advance_i) begin
            cmd_o = CMD_LOAD;
        end else begin
            cmd_o = CMD_ADV;
        end
    end

endmodule

// File: rtl/burst_offset_gen.sv
module burst_offset_gen
    import burst_addr_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  burst_order_e     order_i,
    input  logic [OFS_W-1:0] start_i,
    input  logic [OFS_W-1:0] beat_i,
    output logic [OFS_W-1:0] ofs_o
);

    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    // Linear: wrap-around add; the width truncation gives the modulo
    assign lin_ofs = start_i + beat_i;

    // Interleaved: bitwise XOR of start and beat count
    genvar gi;
    generate
        for (gi = 0; gi < OFS_W; gi++) begin : g_ilv
            assign ilv_ofs[gi] = start_i[gi] ^ beat_i[gi];
        end
    endgenerate

    assign ofs_o = (order_i == ORDER_INTERLEAVE) ? ilv_ofs : lin_ofs;

endmodule

// File: rtl/burst_seq_core.sv
module burst_seq_core
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_cmd_e        cmd_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    input  logic [OFS_W-1:0]  nxt_ofs_i,
    output logic [OFS_W-1:0]  start_o,
    output logic [OFS_W-1:0]  nxt_beat_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              cont_o
);

    localparam int HI_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [OFS_W-1:0]  start;
        logic [OFS_W-1:0]  beat;
        logic              valid;
        logic              cont;
    } seq_state_t;

    seq_state_t st_d, st_q;

    assign nxt_beat_o = st_q.beat + 1'b1;
    assign start_o    = st_q.start;

    always_comb begin
        st_d = st_q;
        unique case (cmd_i)
            CMD_HOLD: begin
                st_d = st_q;
            end
            CMD_DESEL: begin
                st_d.valid = 1'b0;
                st_d.cont  = 1'b0;
            end
            CMD_LOAD: begin
                st_d.addr  = ext_addr_i;
                st_d.start = ext_addr_i[OFS_W-1:0];
                st_d.beat  = '0;
                st_d.valid = 1'b1;
                st_d.cont  = 1'b0;
            end
            CMD_ADV: begin
                if (st_q.valid) begin
                    st_d.addr  = {st_q.addr[ADDR_W-1:OFS_W], nxt_ofs_i};
                    st_d.beat  = nxt_beat_o;
                    st_d.cont  = 1'b1;
                end else begin
                    st_d.cont  = 1'b0;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o  = st_q.addr;
    assign valid_o = st_q.valid;
    assign cont_o  = st_q.cont;

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_LOAD |=> (addr_o == $past(ext_addr_i)) && valid_o && !cont_o);

    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ADV && valid_o)
        |=> (addr_o[ADDR_W-1:OFS_W] == $past(addr_o[ADDR_W-1:OFS_W])) && cont_o);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_HOLD |=> $stable(addr_o) && $stable(valid_o) && $stable(cont_o));

    p_desel_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_DESEL |=> !valid_o && !cont_o);

    p_idle_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ADV && !valid_o) |=> !valid_o);

    p_cont_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cont_o |-> valid_o);

    initial begin
        a_width_r3: assert (HI_W >= 0);
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              sel_i,
    input  logic              advance_i,
    input  logic              order_mode_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o,
    output logic              burst_cont_o
);

    burst_cmd_e       cmd;
    burst_order_e     order;
    logic [OFS_W-1:0] start_ofs;
    logic [OFS_W-1:0] nxt_beat;
    logic [OFS_W-1:0] nxt_ofs;

    assign order = burst_order_e'(order_mode_i);

    burst_cmd_decode u_dec (
        .stall_i   (stall_i),
        .sel_i     (sel_i),
        .advance_i (advance_i),
        .cmd_o     (cmd)
    );

    burst_offset_gen #(.OFS_W(OFS_W)) u_ofs (
        .order_i (order),
        .start_i (start_ofs),
        .beat_i  (nxt_beat),
        .ofs_o   (nxt_ofs)
    );

    burst_seq_core #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .ext_addr_i (ext_addr_i),
        .nxt_ofs_i  (nxt_ofs),
        .start_o    (start_ofs),
        .nxt_beat_o (nxt_beat),
        .addr_o     (addr_o),
        .valid_o    (addr_valid_o),
        .cont_o     (burst_cont_o)
    );

endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        sel = 1'b0;
    logic        adv = 1'b0;
    logic        mode = 1'b0;
    logic [19:0] ext = '0;
    logic [19:0] addr;
    logic        valid;
    logic        cont;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall_i      (stall),
        .sel_i        (sel),
        .advance_i    (adv),
        .order_mode_i (mode),
        .ext_addr_i   (ext),
        .addr_o       (addr),
        .addr_valid_o (valid),
        .burst_cont_o (cont)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic a, input logic st, input logic [19:0] ad);
        @(negedge clk);
        sel = s; adv = a; stall = st; ext = ad;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] expect_ofs(input logic m, input int s, input int k);
        if (m) return 2'(s ^ k);
        return 2'((s + k) % 4);
    endfunction

    task automatic t_reset();
        chk("R1 addr", {12'd0, addr}, 32'd0);
        chk("R1 valid", {31'd0, valid}, 32'd0);
        chk("R1 cont", {31'd0, cont}, 32'd0);
    endtask

    // R4/R5/R6/R3: every start offset, three advances plus a wrap
    task automatic t_order(input logic m);
        mode = m;
        for (int s = 0; s < 4; s++) begin
            logic [19:0] base;
            base = {18'h2D5A3 + 18'(s), 2'(s)};
            drive(1, 0, 0, base);
            chk("R2 load addr", {12'd0, addr}, {12'd0, base});
            chk("R2 load cont", {31'd0, cont}, 32'd0);
            for (int k = 1; k < 5; k++) begin
                drive(1, 1, 0, 20'hFFFFF);
                chk(m ? "R5 interleaved beat" : "R4 linear beat", {12'd0, addr},
                    {12'd0, base[19:2], expect_ofs(m, s, k % 4)});
                chk("R10 cont on advance", {30'd0, valid, cont}, 32'd3);
            end
            chk("R6 wrap to start", {12'd0, addr}, {12'd0, base});
        end
    endtask

    task automatic t_stall();
        mode = 1'b0;
        drive(1, 0, 0, 20'h12341);
        drive(1, 1, 0, 20'h0);
        for (int i = 0; i < 3; i++) begin
            drive(i[0], 1, 1, 20'hABCDE);
            chk("R7 stall addr", {12'd0, addr}, {12'd0, 20'h12342});
            chk("R7 stall flags", {30'd0, valid, cont}, 32'd3);
        end
        drive(1, 1, 0, 20'h0);
        chk("R7 beat resumes", {12'd0, addr}, {12'd0, 20'h12343});
    endtask

    task automatic t_desel();
        drive(1, 0, 0, 20'h55552);
        drive(0, 1, 0, 20'h0);
        chk("R8 deselect", {30'd0, valid, cont}, 32'd0);
        drive(1, 1, 0, 20'h0);
        chk("R9 idle advance", {30'd0, valid, cont}, 32'd0);
        drive(1, 1, 0, 20'h0);
        chk("R9 idle advance twice", {31'd0, valid}, 32'd0);
    endtask

    task automatic t_reload();
        mode = 1'b1;
        drive(1, 0, 0, 20'h0F0F2);
        drive(1, 1, 0, 20'h0);
        chk("R5 first beat", {12'd0, addr}, {12'd0, 20'h0F0F3});
        drive(1, 0, 0, 20'hCAFE1);
        chk("R2 reload mid-burst", {12'd0, addr, 2'b00, valid, cont}, {12'd0, 20'hCAFE1, 4'b0010});
        drive(1, 1, 0, 20'h0);
        chk("R2 beat restarts", {12'd0, addr}, {12'd0, 20'hCAFE0});
    endtask

    initial begin
        #12;
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_order(1'b0);
        t_order(1'b1);
        t_stall();
        t_desel();
        t_reload();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule